// File: doc/BRIEF.md
# Power-Fail Chip-Enable Gating Controller

This controller sits between a host's active-low chip enable and a battery-backed static RAM. It keeps the RAM write-protected whenever the supply is out of tolerance. The analog side is reduced to two asynchronous flags: one from a power-fail comparator, and one that says the supply has dropped below the battery switchover level. The controller re-times both flags and runs a small sequencer. The sequencer passes the host enable through while power is good. When power fails it lets an access that was already running finish, but only up to a timeout. It selects the battery path while the supply is below switchover. On power-up it holds the RAM deselected for a fixed time.

A static threshold-select input picks one of two deselect bands. The controller forwards that choice to the comparator as a one-hot code. Both the drain timeout and the recovery hold are parameters in clock cycles. Their defaults are 5000 cycles (40 µs) and 5,000,000 cycles (40 ms) at 125 MHz.

Top module: `pfail_ce_gate`

## Requirements
- R1: In the pass-through state, `ce_out_n` equals the value `host_ce_n` had one clock earlier.
- R2: `pwr_fail_raw` and `below_sw_raw` each pass through two flip-flops before use. A rise of `pwr_fail_raw` while the host is idle drives `ce_out_n` high on the third rising edge after the change, and it stays high while the flag stays set.
- R3: If the host enable was low and already passed through when the power-fail flag is seen, `ce_out_n` keeps following the host until the host releases. After that it stays high.
- R4: An access that carries on past power-fail is cut after DRAIN_CYCLES cycles: `ce_out_n` goes high even if `host_ce_n` is still low.
- R5: An access that starts after the power-fail flag has been seen never reaches `ce_out_n`.
- R6: While the re-timed below-switchover flag is set, `bat_sel` is 1 and `ce_out_n` is high. Once the flag clears, `bat_sel` returns to 0.
- R7: After the power-fail flag clears, `ce_out_n` stays high for HOLD_CYCLES cycles, whatever the host does. Only then does pass-through resume.
- R8: While reset is asserted, `ce_out_n` is 1 and `bat_sel` is 0. Leaving reset starts a full recovery hold (R7).
- R9: A power-fail during the recovery hold cancels it. The next recovery counts the full HOLD_CYCLES again.
- R10: `thr_code` is a registered one-hot code. `thr_sel`=0 gives 2'b10 (upper deselect band) and `thr_sel`=1 gives 2'b01 (lower band), one cycle after the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_ce_n | input | 1 | Host chip enable, active low |
| pwr_fail_raw | input | 1 | Asynchronous power-fail comparator flag |
| below_sw_raw | input | 1 | Asynchronous below-switchover flag |
| thr_sel | input | 1 | Threshold band select (static) |
| ce_out_n | output | 1 | Conditioned chip enable to the RAM, active low |
| bat_sel | output | 1 | Selects the battery as the RAM supply |
| thr_code | output | 2 | One-hot threshold code to the comparator |

## Verification
The hardest situations to reach are a power-fail that arrives in the middle of an access and lasts longer than the drain timeout, and a second power-fail that lands inside a recovery hold. Both depend on where the host enable sits relative to the re-timed flag. Directed sequences first build a passed-through access and then raise the flag, and they pulse the flag a few cycles into a hold. Random segments of host traffic and flag levels follow, with tight parameters so that timeouts and holds expire often. A cycle-level model built from the requirements is compared with all three outputs on every cycle.

// File: rtl/pfg_pkg.sv
package pfg_pkg;
  typedef enum logic [2:0] {
    ST_RECOVER,
    ST_NORMAL,
    ST_DRAIN,
    ST_PROTECT,
    ST_BATTERY
  } pfg_state_e;

  localparam logic [1:0] THR_UPPER = 2'b10;
  localparam logic [1:0] THR_LOWER = 2'b01;

  function automatic logic [1:0] thr_code_of(input logic sel);
    return sel ? THR_LOWER : THR_UPPER;
  endfunction
endpackage

// File: rtl/pfg_sync.sv
module pfg_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta, held;
    always_ff @(posedge clk) begin
      if (rst) begin
        meta <= 1'b0;
        held <= 1'b0;
      end else begin
        meta <= d[i];
        held <= meta;
      end
    end
    assign q[i] = held;
  end
endmodule

// File: rtl/pfg_timer.sv
module pfg_timer #(
  parameter int CW   = 8,
  parameter int INIT = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= CW'(INIT);
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/pfail_ce_gate.sv
module pfail_ce_gate
  import pfg_pkg::*;
#(
  parameter int DRAIN_CYCLES = 5000,
  parameter int HOLD_CYCLES  = 5000000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       host_ce_n,
  input  logic       pwr_fail_raw,
  input  logic       below_sw_raw,
  input  logic       thr_sel,
  output logic       ce_out_n,
  output logic       bat_sel,
  output logic [1:0] thr_code
);
  localparam int MAXC = (HOLD_CYCLES > DRAIN_CYCLES) ? HOLD_CYCLES : DRAIN_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);

  logic [1:0]    flags_s;
  logic          pf_s, bs_s;
  pfg_state_e    state, nxt;
  logic          tmr_done, tmr_load;
  logic [CW-1:0] tmr_val;

  pfg_sync #(.W(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({below_sw_raw, pwr_fail_raw}),
    .q   (flags_s)
  );
  assign pf_s = flags_s[0];
  assign bs_s = flags_s[1];

  // Sequencer: battery has priority; an access drains only if it was already passed.
  always_comb begin
    nxt = state;
    if (bs_s) begin
      nxt = ST_BATTERY;
    end else begin
      case (state)
        ST_RECOVER: if (pf_s) nxt = ST_PROTECT;
                    else if (tmr_done) nxt = ST_NORMAL;
        ST_NORMAL:  if (pf_s) nxt = (!host_ce_n && !ce_out_n) ? ST_DRAIN : ST_PROTECT;
        ST_DRAIN:   if (host_ce_n || tmr_done) nxt = ST_PROTECT;
        ST_PROTECT: if (!pf_s) nxt = ST_RECOVER;
        ST_BATTERY: nxt = ST_PROTECT;
        default:    nxt = ST_PROTECT;
      endcase
    end
  end

  assign tmr_load = (nxt != state);
  always_comb begin
    case (nxt)
      ST_RECOVER: tmr_val = CW'(HOLD_CYCLES - 1);
      ST_DRAIN:   tmr_val = CW'(DRAIN_CYCLES - 1);
      default:    tmr_val = '0;
    endcase
  end

  pfg_timer #(.CW(CW), .INIT(HOLD_CYCLES - 1)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_RECOVER;
      ce_out_n <= 1'b1;
      bat_sel  <= 1'b0;
    end else begin
      state    <= nxt;
      ce_out_n <= (nxt == ST_NORMAL || nxt == ST_DRAIN) ? host_ce_n : 1'b1;
      bat_sel  <= (nxt == ST_BATTERY);
    end
  end

  always_ff @(posedge clk) thr_code <= thr_code_of(thr_sel);

  // Guard counters for the windowed checks below.
  int unsigned quiet_run, drain_run;
  always_ff @(posedge clk) begin
    if (rst) begin
      quiet_run <= 0;
      drain_run <= 0;
    end else begin
      if (pf_s) quiet_run <= 0;
      else if (quiet_run < HOLD_CYCLES) quiet_run <= quiet_run + 1;
      if (pf_s && !ce_out_n) begin
        if (drain_run < DRAIN_CYCLES + 2) drain_run <= drain_run + 1;
      end else begin
        drain_run <= 0;
      end
    end
  end

  // R2: with the host idle, a seen power-fail keeps the RAM deselected
  p_pf_block_r2: assert property (@(posedge clk) disable iff (rst)
    (pf_s && host_ce_n) |=> ce_out_n);
  // R5: an enable that is blocked under power-fail stays blocked
  p_no_new_r5: assert property (@(posedge clk) disable iff (rst)
    (pf_s && ce_out_n) |=> ce_out_n);
  // R6: switchover flag selects battery and deselects the RAM
  p_bat_r6: assert property (@(posedge clk) disable iff (rst)
    bs_s |=> (bat_sel && ce_out_n));
  // R4: drained access is capped
  p_drain_cap_r4: assert property (@(posedge clk) disable iff (rst)
    drain_run <= DRAIN_CYCLES + 1);
  // R7: enable may only reappear after a full quiet hold
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    ($fell(ce_out_n) && !pf_s) |-> (quiet_run >= HOLD_CYCLES));
endmodule

// File: tb/pfail_ce_gate_tb.sv
module pfail_ce_gate_tb;
  localparam int DRN  = 20;
  localparam int HLD  = 50;
  localparam int S_REC = 0, S_NRM = 1, S_DRN = 2, S_PRT = 3, S_BAT = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic host_ce_n = 1'b1, pwr_fail_raw = 1'b0, below_sw_raw = 1'b0, thr_sel = 1'b0;
  logic ce_out_n, bat_sel;
  logic [1:0] thr_code;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  pfail_ce_gate #(.DRAIN_CYCLES(DRN), .HOLD_CYCLES(HLD)) u_dut (
    .clk(clk), .rst(rst), .host_ce_n(host_ce_n), .pwr_fail_raw(pwr_fail_raw),
    .below_sw_raw(below_sw_raw), .thr_sel(thr_sel),
    .ce_out_n(ce_out_n), .bat_sel(bat_sel), .thr_code(thr_code));

  // Reference behaviour derived from the requirements.
  logic mp1 = 0, mp2 = 0, mb1 = 0, mb2 = 0, mce = 1, mbat = 0;
  logic [1:0] mthr = 2'b10;
  int mst = S_REC, mcnt = HLD - 1;

  function automatic logic [1:0] exp_thr(input logic s);
    return s ? 2'b01 : 2'b10;
  endfunction

  always @(posedge clk) begin
    int nx;
    mthr <= exp_thr(thr_sel);
    if (rst) begin
      mp1 <= 0; mp2 <= 0; mb1 <= 0; mb2 <= 0;
      mst <= S_REC; mcnt <= HLD - 1; mce <= 1; mbat <= 0;
    end else begin
      mp1 <= pwr_fail_raw; mp2 <= mp1; mb1 <= below_sw_raw; mb2 <= mb1;
      nx = mst;
      if (mb2) nx = S_BAT;
      else if (mst == S_REC) nx = mp2 ? S_PRT : ((mcnt == 0) ? S_NRM : S_REC);
      else if (mst == S_NRM) nx = mp2 ? ((!host_ce_n && !mce) ? S_DRN : S_PRT) : S_NRM;
      else if (mst == S_DRN) nx = (host_ce_n || mcnt == 0) ? S_PRT : S_DRN;
      else if (mst == S_PRT) nx = mp2 ? S_PRT : S_REC;
      else nx = S_PRT;
      if (nx != mst) mcnt <= (nx == S_REC) ? HLD - 1 : ((nx == S_DRN) ? DRN - 1 : 0);
      else if (mcnt != 0) mcnt <= mcnt - 1;
      mst  <= nx;
      mce  <= (nx == S_NRM || nx == S_DRN) ? host_ce_n : 1'b1;
      mbat <= (nx == S_BAT);
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  bit started = 0;
  always @(negedge clk) begin
    if (started && !rst) begin
      string tag;
      case (mst)
        S_REC: tag = "R7";
        S_NRM: tag = "R1";
        S_DRN: tag = "R3";
        S_PRT: tag = "R2";
        default: tag = "R6";
      endcase
      chk(ce_out_n === mce, tag, ce_out_n, mce);
      chk(bat_sel === mbat, "R6", bat_sel, mbat);
      chk(thr_code === mthr, "R10", thr_code, mthr);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    tick(3);
    chk(ce_out_n === 1'b1, "R8", ce_out_n, 1);
    chk(bat_sel === 1'b0, "R8", bat_sel, 0);
    rst = 1'b0; started = 1;
    host_ce_n = 1'b0;
    tick(HLD - 2);
    chk(ce_out_n === 1'b1, "R8", ce_out_n, 1);   // hold after reset
    tick(4);
    chk(ce_out_n === 1'b0, "R7", ce_out_n, 0);
    host_ce_n = 1'b1; tick(1);
    chk(ce_out_n === 1'b1, "R1", ce_out_n, 1);
    thr_sel = 1'b1; tick(1);
    chk(thr_code === 2'b01, "R10", thr_code, 1);
    thr_sel = 1'b0;

    // R3 then R4: access in flight, timeout cuts it
    host_ce_n = 1'b0; tick(3);
    pwr_fail_raw = 1'b1;
    tick(DRN);
    chk(ce_out_n === 1'b0, "R3", ce_out_n, 0);
    tick(4);
    chk(ce_out_n === 1'b1, "R4", ce_out_n, 1);
    host_ce_n = 1'b1; tick(3);
    // R5: new access after detection is blocked
    host_ce_n = 1'b0; tick(6);
    chk(ce_out_n === 1'b1, "R5", ce_out_n, 1);
    // R6: switchover
    below_sw_raw = 1'b1; tick(4);
    chk(bat_sel === 1'b1, "R6", bat_sel, 1);
    below_sw_raw = 1'b0; tick(4);
    chk(bat_sel === 1'b0, "R6", bat_sel, 0);
    // R9: abort hold and restart
    pwr_fail_raw = 1'b0; tick(15);
    pwr_fail_raw = 1'b1; tick(6);
    pwr_fail_raw = 1'b0;
    tick(HLD + 1);
    chk(ce_out_n === 1'b1, "R9", ce_out_n, 1);
    tick(3);
    chk(ce_out_n === 1'b0, "R9", ce_out_n, 0);
    // R3: drained access released by host
    tick(2); pwr_fail_raw = 1'b1; tick(5);
    host_ce_n = 1'b1; tick(1);
    chk(ce_out_n === 1'b1, "R3", ce_out_n, 1);
    host_ce_n = 1'b0; tick(3);
    chk(ce_out_n === 1'b1, "R5", ce_out_n, 1);
    pwr_fail_raw = 1'b0; tick(HLD + 5);

    // Random segments
    for (int s = 0; s < 400; s++) begin
      int len = 3 + int'($urandom % 90);
      pwr_fail_raw = ($urandom % 4 == 0);
      below_sw_raw = pwr_fail_raw && ($urandom % 3 == 0);
      if ($urandom % 10 == 0) thr_sel = ~thr_sel;
      for (int c = 0; c < len; c++) begin
        if ($urandom % 6 == 0) host_ce_n = ~host_ce_n;
        tick(1);
      end
    end
    pwr_fail_raw = 1'b0; below_sw_raw = 1'b0;
    tick(HLD + 10);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule